// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every memory access, whether it may proceed. It holds a small set of programmable address windows. Each window has a lower bound, an upper bound, an enable and separate read and write permissions. A requester drives an address and a read/write flag. The block answers combinationally with grant or deny, based on the windows currently programmed. An address outside every enabled window is denied.

Windows may cover the same addresses, and the block resolves such overlaps in one of two ways. In priority mode the enabled window with the smallest index decides. In all-agree mode every enabled window covering the address must permit the access type. Trusted software can also turn on a hardware guard in the configuration path. While the guard is on, a window write that would overlap another enabled window is refused, the table keeps its old contents, and a sticky error flag is raised. The mode, the guard and the error flag live in a control register. Like the windows, that register changes only when the trusted-configuration strobe is high.

Top module: `mpu_region_guard`

## Requirements
- R1: Window i covers address A when it is enabled and base_i <= A <= limit_i, inclusive at both ends. A window whose limit is below its base covers nothing. The read permission applies when acc_is_write is 0, and the write permission applies when acc_is_write is 1.
- R2: An access that no enabled window covers is denied (acc_grant = 0).
- R3: In priority mode (cfg_ctl_mode = 0), only the covering window with the lowest index decides the result.
- R4: In all-agree mode (cfg_ctl_mode = 1), an access is granted only if every covering enabled window permits that access type.
- R5: While the overlap guard is on (cfg_ctl_ovchk = 1), a window write is refused and leaves the table unchanged if the new window is enabled, non-empty, and intersects another enabled, non-empty window. Writes that do not overlap are accepted. A window written as disabled never counts as overlapping.
- R6: A refused window write sets cfg_err. cfg_err then stays set until a trusted control write carries cfg_ctl_errclr = 1.
- R7: While the overlap guard is off, overlapping window writes are accepted and resolved by the current mode. cfg_err is not set by them.
- R8: Window and control writes take effect only when cfg_trusted is 1. Otherwise they change nothing, including the mode.
- R9: After reset, every window is disabled with no permissions, the mode is priority, the guard is off, cfg_err is 0, and every access is denied.
- R10: A configuration write takes effect at the next rising clock edge. acc_grant is combinational on the current register state and the access inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_trusted | input | 1 | Trusted-configuration strobe; gates all writes |
| cfg_rgn_we | input | 1 | Window write request |
| cfg_rgn_idx | input | IDX_W | Index of the window being written |
| cfg_rgn_base | input | ADDR_W | New lower bound |
| cfg_rgn_limit | input | ADDR_W | New upper bound (inclusive) |
| cfg_rgn_en | input | 1 | New enable |
| cfg_rgn_rd | input | 1 | New read permission |
| cfg_rgn_wr | input | 1 | New write permission |
| cfg_ctl_we | input | 1 | Control register write request |
| cfg_ctl_mode | input | 1 | Resolution mode: 0 priority, 1 all-agree |
| cfg_ctl_ovchk | input | 1 | Overlap guard enable |
| cfg_ctl_errclr | input | 1 | Write 1 to clear cfg_err |
| acc_addr | input | ADDR_W | Access address |
| acc_is_write | input | 1 | 1 for a write access, 0 for a read |
| acc_grant | output | 1 | 1 when the access is allowed |
| cfg_err | output | 1 | Sticky flag for a refused window write |

## Verification
The bench probes both ends of each window and the addresses just outside them. A comparison that is off by one, or a match that forgets the enable, would grant a neighbour address or deny an edge. It builds two overlapping pairs in which the lower index and the higher index disagree, so that swapping the priority direction or mixing up the modes flips a visible grant. It sends a refused overlap, an accepted disjoint write, a disabled overlapping write and an untrusted mode change. A missing guard, a partial update, a self-comparison, a sticky flag that clears on its own or a strobe that is ignored each shows up as a changed grant or cfg_err. It also samples the grant just before and just after a write edge, to catch a write that bypasses the register.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  typedef enum logic {
    MODE_PRIORITY  = 1'b0,
    MODE_ALL_AGREE = 1'b1
  } mode_e;

  typedef struct packed {
    logic en;
    logic rd;
    logic wr;
  } perm_t;

endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int NUM_REG = 4,
  parameter int ADDR_W  = 32
) (
  input  logic [NUM_REG-1:0][ADDR_W-1:0] base_q,
  input  logic [NUM_REG-1:0][ADDR_W-1:0] limit_q,
  input  perm_t [NUM_REG-1:0]            perm_q,
  input  logic [ADDR_W-1:0]              acc_addr,
  input  logic                           acc_is_write,
  output logic [NUM_REG-1:0]             hit_vec,
  output logic [NUM_REG-1:0]             allow_vec
);

  for (genvar i = 0; i < NUM_REG; i++) begin : g_win
    logic above_lo;
    logic below_hi;

    assign above_lo     = (acc_addr >= base_q[i]);
    assign below_hi     = (acc_addr <= limit_q[i]);
    assign hit_vec[i]   = perm_q[i].en & above_lo & below_hi;
    assign allow_vec[i] = acc_is_write ? perm_q[i].wr : perm_q[i].rd;
  end

endmodule

// File: rtl/mpu_resolve.sv
module mpu_resolve
  import mpu_pkg::*;
#(
  parameter int NUM_REG = 4
) (
  input  mode_e              mode,
  input  logic [NUM_REG-1:0] hit_vec,
  input  logic [NUM_REG-1:0] allow_vec,
  output logic               grant
);

  logic any_hit;
  logic first_allow;
  logic all_allow;

  assign any_hit = |hit_vec;

  // Walk from the top index down so the lowest hit is the last one written.
  always_comb begin
    first_allow = 1'b0;
    for (int i = NUM_REG - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        first_allow = allow_vec[i];
      end
    end
  end

  assign all_allow = &(allow_vec | ~hit_vec);

  always_comb begin
    unique case (mode)
      MODE_PRIORITY:  grant = any_hit & first_allow;
      MODE_ALL_AGREE: grant = any_hit & all_allow;
      default:        grant = 1'b0;
    endcase
  end

endmodule

// File: rtl/mpu_overlap_chk.sv
module mpu_overlap_chk #(
  parameter int NUM_REG = 4,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic [IDX_W-1:0]               cand_idx,
  input  logic [ADDR_W-1:0]              cand_base,
  input  logic [ADDR_W-1:0]              cand_limit,
  input  logic                           cand_en,
  input  logic [NUM_REG-1:0][ADDR_W-1:0] base_q,
  input  logic [NUM_REG-1:0][ADDR_W-1:0] limit_q,
  input  logic [NUM_REG-1:0]             en_q,
  output logic                           conflict
);

  logic                cand_live;
  logic [NUM_REG-1:0]  clash;

  assign cand_live = cand_en & (cand_limit >= cand_base);

  for (genvar j = 0; j < NUM_REG; j++) begin : g_pair
    logic other_live;
    logic same_slot;
    logic ranges_meet;

    assign other_live  = en_q[j] & (limit_q[j] >= base_q[j]);
    assign same_slot   = (cand_idx == IDX_W'(j));
    assign ranges_meet = (cand_base <= limit_q[j]) & (base_q[j] <= cand_limit);
    assign clash[j]    = ~same_slot & other_live & ranges_meet;
  end

  assign conflict = cand_live & (|clash);

endmodule

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
  import mpu_pkg::*;
#(
  parameter int NUM_REG = 4,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_trusted,
  input  logic                           rgn_we,
  input  logic [IDX_W-1:0]               rgn_idx,
  input  logic [ADDR_W-1:0]              rgn_base,
  input  logic [ADDR_W-1:0]              rgn_limit,
  input  perm_t                          rgn_perm,
  input  logic                           ctl_we,
  input  logic                           ctl_mode,
  input  logic                           ctl_ovchk,
  input  logic                           ctl_errclr,
  input  logic                           conflict,
  output logic [NUM_REG-1:0][ADDR_W-1:0] base_q,
  output logic [NUM_REG-1:0][ADDR_W-1:0] limit_q,
  output perm_t [NUM_REG-1:0]            perm_q,
  output mode_e                          mode_q,
  output logic                           ovchk_q,
  output logic                           err_q,
  output logic                           rgn_reject
);

  logic idx_ok;
  logic rgn_try;
  logic rgn_commit;
  logic ctl_commit;
  logic err_en;
  logic err_d;

  if (NUM_REG == (1 << IDX_W)) begin : g_idx_full
    assign idx_ok = 1'b1;
  end else begin : g_idx_part
    assign idx_ok = (rgn_idx <= IDX_W'(NUM_REG - 1));
  end

  assign rgn_try    = cfg_trusted & rgn_we & idx_ok;
  assign rgn_reject = rgn_try & ovchk_q & conflict;
  assign rgn_commit = rgn_try & ~rgn_reject;
  assign ctl_commit = cfg_trusted & ctl_we;

  // Window slots: one clock enable per slot.
  for (genvar i = 0; i < NUM_REG; i++) begin : g_slot
    logic slot_en;

    assign slot_en = rgn_commit & (rgn_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        perm_q[i]  <= '0;
      end else if (slot_en) begin
        base_q[i]  <= rgn_base;
        limit_q[i] <= rgn_limit;
        perm_q[i]  <= rgn_perm;
      end
    end
  end

  // Control register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_PRIORITY;
      ovchk_q <= 1'b0;
    end else if (ctl_commit) begin
      mode_q  <= mode_e'(ctl_mode);
      ovchk_q <= ctl_ovchk;
    end
  end

  // Sticky error: a refusal wins over a clear in the same cycle.
  always_comb begin
    err_en = 1'b0;
    err_d  = err_q;
    if (rgn_reject) begin
      err_en = 1'b1;
      err_d  = 1'b1;
    end else if (ctl_commit & ctl_errclr) begin
      err_en = 1'b1;
      err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/mpu_region_guard.sv
module mpu_region_guard
  import mpu_pkg::*;
#(
  parameter int NUM_REG = 4,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_trusted,
  input  logic              cfg_rgn_we,
  input  logic [IDX_W-1:0]  cfg_rgn_idx,
  input  logic [ADDR_W-1:0] cfg_rgn_base,
  input  logic [ADDR_W-1:0] cfg_rgn_limit,
  input  logic              cfg_rgn_en,
  input  logic              cfg_rgn_rd,
  input  logic              cfg_rgn_wr,
  input  logic              cfg_ctl_we,
  input  logic              cfg_ctl_mode,
  input  logic              cfg_ctl_ovchk,
  input  logic              cfg_ctl_errclr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_is_write,
  output logic              acc_grant,
  output logic              cfg_err
);

  logic                           rst_meta_n;
  logic                           rst_sync_n;
  logic [NUM_REG-1:0][ADDR_W-1:0] base_q;
  logic [NUM_REG-1:0][ADDR_W-1:0] limit_q;
  perm_t [NUM_REG-1:0]            perm_q;
  logic [NUM_REG-1:0]             en_vec;
  mode_e                          mode_q;
  logic                           ovchk_q;
  logic                           rgn_reject;
  logic                           conflict;
  logic [NUM_REG-1:0]             hit_vec;
  logic [NUM_REG-1:0]             allow_vec;
  perm_t                          new_perm;

  // Reset: asserted at once, released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign new_perm = '{en: cfg_rgn_en, rd: cfg_rgn_rd, wr: cfg_rgn_wr};

  for (genvar i = 0; i < NUM_REG; i++) begin : g_en
    assign en_vec[i] = perm_q[i].en;
  end

  mpu_overlap_chk #(
    .NUM_REG (NUM_REG),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
  ) u_overlap (
    .cand_idx   (cfg_rgn_idx),
    .cand_base  (cfg_rgn_base),
    .cand_limit (cfg_rgn_limit),
    .cand_en    (cfg_rgn_en),
    .base_q     (base_q),
    .limit_q    (limit_q),
    .en_q       (en_vec),
    .conflict   (conflict)
  );

  mpu_cfg_regs #(
    .NUM_REG (NUM_REG),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_trusted (cfg_trusted),
    .rgn_we      (cfg_rgn_we),
    .rgn_idx     (cfg_rgn_idx),
    .rgn_base    (cfg_rgn_base),
    .rgn_limit   (cfg_rgn_limit),
    .rgn_perm    (new_perm),
    .ctl_we      (cfg_ctl_we),
    .ctl_mode    (cfg_ctl_mode),
    .ctl_ovchk   (cfg_ctl_ovchk),
    .ctl_errclr  (cfg_ctl_errclr),
    .conflict    (conflict),
    .base_q      (base_q),
    .limit_q     (limit_q),
    .perm_q      (perm_q),
    .mode_q      (mode_q),
    .ovchk_q     (ovchk_q),
    .err_q       (cfg_err),
    .rgn_reject  (rgn_reject)
  );

  mpu_region_match #(
    .NUM_REG (NUM_REG),
    .ADDR_W  (ADDR_W)
  ) u_match (
    .base_q       (base_q),
    .limit_q      (limit_q),
    .perm_q       (perm_q),
    .acc_addr     (acc_addr),
    .acc_is_write (acc_is_write),
    .hit_vec      (hit_vec),
    .allow_vec    (allow_vec)
  );

  mpu_resolve #(
    .NUM_REG (NUM_REG)
  ) u_resolve (
    .mode      (mode_q),
    .hit_vec   (hit_vec),
    .allow_vec (allow_vec),
    .grant     (acc_grant)
  );

endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk
  import mpu_pkg::*;
#(
  parameter int NUM_REG = 4,
  parameter int ADDR_W  = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cfg_trusted,
  input logic                           cfg_ctl_we,
  input logic                           cfg_ctl_errclr,
  input logic                           rgn_reject,
  input logic                           cfg_err,
  input mode_e                          mode_q,
  input logic                           ovchk_q,
  input logic [NUM_REG-1:0][ADDR_W-1:0] base_q,
  input logic [NUM_REG-1:0][ADDR_W-1:0] limit_q,
  input perm_t [NUM_REG-1:0]            perm_q,
  input logic [NUM_REG-1:0]             hit_vec,
  input logic [NUM_REG-1:0]             allow_vec,
  input logic                           acc_grant
);

  assert_default_deny_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant |-> (|hit_vec));

  assert_lowest_decides_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PRIORITY) && hit_vec[0] |-> (acc_grant == allow_vec[0]));

  assert_all_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ALL_AGREE) && acc_grant |-> ((hit_vec & ~allow_vec) == '0));

  assert_reject_keeps_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_reject |=> $stable(base_q) && $stable(limit_q) && $stable(perm_q));

  assert_reject_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_reject |=> cfg_err);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !(cfg_trusted && cfg_ctl_we && cfg_ctl_errclr) |=> cfg_err);

  assert_untrusted_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_trusted |=> $stable(mode_q) && $stable(ovchk_q) && $stable(cfg_err));

  assert_untrusted_rgn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_trusted |=> $stable(base_q) && $stable(limit_q) && $stable(perm_q));

endmodule

bind mpu_region_guard mpu_guard_chk #(
  .NUM_REG (NUM_REG),
  .ADDR_W  (ADDR_W)
) u_guard_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .cfg_trusted    (cfg_trusted),
  .cfg_ctl_we     (cfg_ctl_we),
  .cfg_ctl_errclr (cfg_ctl_errclr),
  .rgn_reject     (rgn_reject),
  .cfg_err        (cfg_err),
  .mode_q         (mode_q),
  .ovchk_q        (ovchk_q),
  .base_q         (base_q),
  .limit_q        (limit_q),
  .perm_q         (perm_q),
  .hit_vec        (hit_vec),
  .allow_vec      (allow_vec),
  .acc_grant      (acc_grant)
);

// File: tb/tb_mpu_region_guard.sv
module tb_mpu_region_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int AW = 32;
  localparam int IW = 2;

  logic          clk;
  logic          rst_n;
  logic          cfg_trusted;
  logic          cfg_rgn_we;
  logic [IW-1:0] cfg_rgn_idx;
  logic [AW-1:0] cfg_rgn_base;
  logic [AW-1:0] cfg_rgn_limit;
  logic          cfg_rgn_en;
  logic          cfg_rgn_rd;
  logic          cfg_rgn_wr;
  logic          cfg_ctl_we;
  logic          cfg_ctl_mode;
  logic          cfg_ctl_ovchk;
  logic          cfg_ctl_errclr;
  logic [AW-1:0] acc_addr;
  logic          acc_is_write;
  logic          acc_grant;
  logic          cfg_err;

  mpu_region_guard #(.NUM_REG(NR), .ADDR_W(AW)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_trusted    (cfg_trusted),
    .cfg_rgn_we     (cfg_rgn_we),
    .cfg_rgn_idx    (cfg_rgn_idx),
    .cfg_rgn_base   (cfg_rgn_base),
    .cfg_rgn_limit  (cfg_rgn_limit),
    .cfg_rgn_en     (cfg_rgn_en),
    .cfg_rgn_rd     (cfg_rgn_rd),
    .cfg_rgn_wr     (cfg_rgn_wr),
    .cfg_ctl_we     (cfg_ctl_we),
    .cfg_ctl_mode   (cfg_ctl_mode),
    .cfg_ctl_ovchk  (cfg_ctl_ovchk),
    .cfg_ctl_errclr (cfg_ctl_errclr),
    .acc_addr       (acc_addr),
    .acc_is_write   (acc_is_write),
    .acc_grant      (acc_grant),
    .cfg_err        (cfg_err)
  );

  typedef struct {
    logic  exp;
    string tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sample_ev;
  int       n_chk  = 0;
  int       n_fail = 0;
  bit       done   = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Monitor: pops the expected grant and compares with the output.
  initial begin
    forever begin
      @(sample_ev);
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (acc_grant !== it.exp) begin
          n_fail++;
          $display("FAIL %s: addr=%h wr=%0b grant=%0b expected=%0b",
                   it.tag, acc_addr, acc_is_write, acc_grant, it.exp);
        end
      end
    end
  end

  // Pushes an expectation for the inputs already driven and triggers the monitor.
  task automatic sample_now(input logic e, input string tag);
    sb_item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    #1;
    -> sample_ev;
    #1;
  endtask

  task automatic expect_acc(input logic [AW-1:0] a, input logic w, input logic e,
                            input string tag);
    @(negedge clk);
    acc_addr     = a;
    acc_is_write = w;
    sample_now(e, tag);
  endtask

  task automatic expect_err(input logic e, input string tag);
    @(negedge clk);
    #1;
    n_chk++;
    if (cfg_err !== e) begin
      n_fail++;
      $display("FAIL %s: cfg_err=%0b expected=%0b", tag, cfg_err, e);
    end
  endtask

  task automatic wr_region(input logic t, input int idx, input logic [AW-1:0] b,
                           input logic [AW-1:0] l, input logic en, input logic rd,
                           input logic wr);
    @(negedge clk);
    cfg_trusted   = t;
    cfg_rgn_we    = 1'b1;
    cfg_rgn_idx   = IW'(idx);
    cfg_rgn_base  = b;
    cfg_rgn_limit = l;
    cfg_rgn_en    = en;
    cfg_rgn_rd    = rd;
    cfg_rgn_wr    = wr;
    @(negedge clk);
    cfg_rgn_we  = 1'b0;
    cfg_trusted = 1'b1;
  endtask

  task automatic wr_ctl(input logic t, input logic mode, input logic ov, input logic clr);
    @(negedge clk);
    cfg_trusted    = t;
    cfg_ctl_we     = 1'b1;
    cfg_ctl_mode   = mode;
    cfg_ctl_ovchk  = ov;
    cfg_ctl_errclr = clr;
    @(negedge clk);
    cfg_ctl_we     = 1'b0;
    cfg_ctl_errclr = 1'b0;
    cfg_trusted    = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cfg_trusted = 1'b1; cfg_rgn_we = 1'b0; cfg_rgn_idx = '0;
    cfg_rgn_base = '0; cfg_rgn_limit = '0;
    cfg_rgn_en = 1'b0; cfg_rgn_rd = 1'b0; cfg_rgn_wr = 1'b0;
    cfg_ctl_we = 1'b0; cfg_ctl_mode = 1'b0; cfg_ctl_ovchk = 1'b0; cfg_ctl_errclr = 1'b0;
    acc_addr = '0; acc_is_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state
    expect_acc(32'h0000_0000, 1'b0, 1'b0, "R9");
    expect_acc(32'h0000_0000, 1'b1, 1'b0, "R9");
    expect_err(1'b0, "R9");

    // R1 / R2: window 0 covers 0x1000..0x1FFF, read only
    wr_region(1'b1, 0, 32'h1000, 32'h1FFF, 1'b1, 1'b1, 1'b0);
    expect_acc(32'h1000, 1'b0, 1'b1, "R1");
    expect_acc(32'h1FFF, 1'b0, 1'b1, "R1");
    expect_acc(32'h1800, 1'b1, 1'b0, "R1");
    expect_acc(32'h0FFF, 1'b0, 1'b0, "R2");
    expect_acc(32'h2000, 1'b0, 1'b0, "R2");

    // R10: grant follows the register, not the write inputs
    @(negedge clk);
    cfg_trusted = 1'b1; cfg_rgn_we = 1'b1; cfg_rgn_idx = 2'd1;
    cfg_rgn_base = 32'h3000; cfg_rgn_limit = 32'h3FFF;
    cfg_rgn_en = 1'b1; cfg_rgn_rd = 1'b1; cfg_rgn_wr = 1'b1;
    acc_addr = 32'h3000; acc_is_write = 1'b0;
    sample_now(1'b0, "R10");
    @(posedge clk);
    sample_now(1'b1, "R10");
    @(negedge clk);
    cfg_rgn_we = 1'b0;

    // R1: window with limit below base covers nothing
    wr_region(1'b1, 2, 32'h5000, 32'h4000, 1'b1, 1'b1, 1'b1);
    expect_acc(32'h4800, 1'b0, 1'b0, "R1");
    expect_acc(32'h5000, 1'b0, 1'b0, "R1");
    expect_acc(32'h4000, 1'b1, 1'b0, "R1");

    // R7: guard off, overlapping writes are accepted
    wr_region(1'b1, 2, 32'h1800, 32'h27FF, 1'b1, 1'b1, 1'b1);
    wr_region(1'b1, 3, 32'h3800, 32'h38FF, 1'b1, 1'b1, 1'b0);
    expect_acc(32'h2000, 1'b1, 1'b1, "R7");
    expect_err(1'b0, "R7");

    // R3: lowest index decides
    expect_acc(32'h1800, 1'b1, 1'b0, "R3");
    expect_acc(32'h3800, 1'b1, 1'b1, "R3");
    expect_acc(32'h1800, 1'b0, 1'b1, "R3");

    // R4: all covering windows must agree
    wr_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    expect_acc(32'h3800, 1'b1, 1'b0, "R4");
    expect_acc(32'h3800, 1'b0, 1'b1, "R4");
    expect_acc(32'h1800, 1'b0, 1'b1, "R4");
    expect_acc(32'h3000, 1'b1, 1'b1, "R4");

    // R8: untrusted writes change nothing
    wr_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    expect_acc(32'h3800, 1'b1, 1'b0, "R8");
    wr_region(1'b0, 1, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    expect_acc(32'h3000, 1'b0, 1'b1, "R8");

    // R5 / R6: guard on, overlapping write refused
    wr_ctl(1'b1, 1'b1, 1'b1, 1'b0);
    wr_region(1'b1, 0, 32'h3F00, 32'h40FF, 1'b1, 1'b1, 1'b0);
    expect_err(1'b1, "R6");
    expect_acc(32'h1000, 1'b0, 1'b1, "R5");
    expect_acc(32'h4000, 1'b0, 1'b0, "R5");

    // R5 / R6: disjoint write accepted, error stays set
    wr_region(1'b1, 0, 32'h6000, 32'h60FF, 1'b1, 1'b1, 1'b0);
    expect_acc(32'h6000, 1'b0, 1'b1, "R5");
    expect_acc(32'h1000, 1'b0, 1'b0, "R5");
    expect_err(1'b1, "R6");

    // R6: only a write of 1 clears; R8: untrusted clear ignored
    wr_ctl(1'b1, 1'b1, 1'b1, 1'b0);
    expect_err(1'b1, "R6");
    wr_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    expect_err(1'b1, "R8");
    wr_ctl(1'b1, 1'b1, 1'b1, 1'b1);
    expect_err(1'b0, "R6");

    // R5: a disabled window never counts as overlapping
    wr_region(1'b1, 3, 32'h3000, 32'h3FFF, 1'b0, 1'b0, 1'b0);
    expect_err(1'b0, "R5");
    expect_acc(32'h3800, 1'b1, 1'b1, "R5");

    @(negedge clk);
    finish_run();
  end

endmodule